// File: doc/BRIEF.md
# Desaturation Protection and Soft-Shutdown Channel

This block controls the output stage of one power switch. One copy serves the high side of a half bridge and a second copy serves the low side. It takes a level on/off command and the digital output of an external desaturation comparator. From these it drives one-hot enables for three output stages: a sourcing stage that turns the switch on, a sinking stage that turns it off, and a weak pull-down for soft shutdown. It also drives a short boost enable that adds drive strength at the start of every turn-on.

While the switch is commanded on, the channel watches the comparator. It ignores the comparator for a blanking window after each turn-on, and a glitch filter must confirm any assertion. A confirmed desaturation releases both normal stages and runs the soft pull-down for a fixed time. During that time the channel reports that soft shutdown is in progress. At the end it emits a one-cycle completion pulse and parks in a held-off state. A fault manager outside the block frees the channel again by pulsing the force-off input. Every duration is a parameter counted in clock cycles.

Top module: `dsat_ssd_chan`

## Requirements
- R1: While the synchronous active-low reset is low at a clock edge, the next cycle shows the off encoding (sink enable only), with boost, soft-shutdown-active and done all low.
- R2: Stage enables are one-hot: off shows only the sink enable, on shows only the source enable, soft shutdown shows only the pull-down enable.
- R3: With force-off low, a high command turns the source stage on one cycle later, and a low command returns the channel to off one cycle later. A high force-off keeps the channel off, or turns it off one cycle later, unless R11 applies.
- R4: Each turn-on raises the boost enable for exactly BOOST_CYC cycles, starting in the first on cycle. The source enable stays high for the whole on time.
- R5: During the first BLANK_CYC cycles of every on period, the desaturation input is ignored.
- R6: After blanking, desaturation must be high for FILT_CYC consecutive cycles. Soft shutdown then starts in the next cycle. Any shorter run is discarded.
- R7: Desaturation has no effect while the channel is off or commanded off.
- R8: Soft shutdown lasts exactly SSD_CYC cycles. The active flag is high throughout, and the command, force-off and desaturation inputs are all ignored.
- R9: When soft shutdown ends, the done flag is high for exactly one cycle while the channel shows the off encoding.
- R10: After soft shutdown the channel stays off regardless of the command. It leaves this held state only one cycle after a falling edge of force-off (high in one cycle, low in the next), and may then turn on again.
- R11: If a confirmed desaturation and a high force-off fall in the same on cycle, soft shutdown wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every duration counts its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_on | input | 1 | Level command, 1 = switch on |
| desat_in | input | 1 | Desaturation comparator output, 1 = desaturated |
| force_off | input | 1 | Hard off from the fault manager; its falling edge frees the held state |
| src_en | output | 1 | Sourcing (turn-on) stage enable |
| snk_en | output | 1 | Sinking (turn-off) stage enable |
| ssd_en | output | 1 | Soft-shutdown pull-down enable |
| boost_en | output | 1 | First turn-on stage boost enable |
| ssd_active | output | 1 | Soft shutdown in progress |
| ssd_done | output | 1 | One-cycle pulse when soft shutdown completes |

## Verification
Two functions can collide in one cycle. The glitch filter can reach its confirming count in the very cycle that the fault manager raises force-off for a hard turn-off. The bench provokes this by keeping desaturation high after blanking and raising force-off on the exact cycle the filter completes. It then requires the pull-down enable, not the sink enable, in the following cycle. A second overlap occurs when the command and force-off both change during soft shutdown. That case is judged by seeing the pull-down hold for its full length with both normal stages released.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

   typedef enum logic [1:0] {
      CH_OFF  = 2'd0,
      CH_ON   = 2'd1,
      CH_SSD  = 2'd2,
      CH_HOLD = 2'd3
   } ch_state_e;

   function automatic int cnt_bits(input int max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/dsc_window_timer.sv
module dsc_window_timer #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int W = dsc_pkg::cnt_bits(CYC);
   localparam logic [W-1:0] LIMIT = W'(CYC);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run)
         cnt <= '0;
      else if (cnt != LIMIT)
         cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LIMIT);
endmodule

// File: rtl/dsc_glitch_filter.sv
module dsc_glitch_filter #(
   parameter int FILT_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sense,
   output logic confirm
);
   generate
      if (FILT_CYC == 1) begin : g_direct
         assign confirm = sense;
      end else begin : g_count
         localparam int W = dsc_pkg::cnt_bits(FILT_CYC - 1);
         localparam logic [W-1:0] LAST = W'(FILT_CYC - 1);
         logic [W-1:0] run_len;

         always_ff @(posedge clk) begin
            if (!rst_n || !sense)
               run_len <= '0;
            else if (run_len != LAST)
               run_len <= run_len + 1'b1;
         end

         assign confirm = sense && (run_len == LAST);
      end
   endgenerate
endmodule

// File: rtl/dsc_oneshot.sv
module dsc_oneshot #(
   parameter int LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic keep,
   output logic pulse
);
   localparam int W = dsc_pkg::cnt_bits(LEN);
   localparam logic [W-1:0] LOAD = W'(LEN);

   logic [W-1:0] left;

   always_ff @(posedge clk) begin
      if (!rst_n)
         left <= '0;
      else if (fire)
         left <= LOAD;
      else if (!keep)
         left <= '0;
      else if (left != '0)
         left <= left - 1'b1;
   end

   assign pulse = (left != '0);
endmodule

// File: rtl/dsat_ssd_chan.sv
module dsat_ssd_chan #(
   parameter int BLANK_CYC = 150,
   parameter int FILT_CYC  = 50,
   parameter int SSD_CYC   = 480,
   parameter int BOOST_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_on,
   input  logic desat_in,
   input  logic force_off,
   output logic src_en,
   output logic snk_en,
   output logic ssd_en,
   output logic boost_en,
   output logic ssd_active,
   output logic ssd_done
);
   import dsc_pkg::*;

   generate
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("BLANK_CYC must be at least 1");
      end
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("FILT_CYC must be at least 1");
      end
      if (SSD_CYC < 2) begin : g_bad_ssd
         $error("SSD_CYC must be at least 2");
      end
      if (BOOST_CYC < 1) begin : g_bad_boost
         $error("BOOST_CYC must be at least 1");
      end
   endgenerate

   ch_state_e state, nxt;
   logic      blank_over;
   logic      sense;
   logic      confirm;
   logic      ssd_last;
   logic      force_q;
   logic      done_q;
   logic      boost_pulse;

   // blanking window: restarts every time the channel enters the on state
   dsc_window_timer #(.CYC(BLANK_CYC)) u_blank (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == CH_ON),
      .done (blank_over)
   );

   // sensing only while on, commanded on and past blanking
   assign sense = (state == CH_ON) && cmd_on && desat_in && blank_over;

   dsc_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .sense  (sense),
      .confirm(confirm)
   );

   // soft-shutdown length: last cycle flagged after SSD_CYC-1 counts
   dsc_window_timer #(.CYC(SSD_CYC - 1)) u_ssd_len (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == CH_SSD),
      .done (ssd_last)
   );

   always_comb begin
      nxt = state;
      unique case (state)
         CH_OFF: begin
            if (cmd_on && !force_off)
               nxt = CH_ON;
         end
         CH_ON: begin
            if (confirm)
               nxt = CH_SSD;
            else if (!cmd_on || force_off)
               nxt = CH_OFF;
         end
         CH_SSD: begin
            if (ssd_last)
               nxt = CH_HOLD;
         end
         CH_HOLD: begin
            if (force_q && !force_off)
               nxt = CH_OFF;
         end
         default: nxt = CH_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= CH_OFF;
         force_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state   <= nxt;
         force_q <= force_off;
         done_q  <= (state == CH_SSD) && ssd_last;
      end
   end

   dsc_oneshot #(.LEN(BOOST_CYC)) u_boost (
      .clk  (clk),
      .rst_n(rst_n),
      .fire ((nxt == CH_ON) && (state != CH_ON)),
      .keep (nxt == CH_ON),
      .pulse(boost_pulse)
   );

   assign src_en     = (state == CH_ON);
   assign snk_en     = (state == CH_OFF) || (state == CH_HOLD);
   assign ssd_en     = (state == CH_SSD);
   assign ssd_active = (state == CH_SSD);
   assign boost_en   = boost_pulse;
   assign ssd_done   = done_q;
endmodule

// File: rtl/dsat_ssd_chan_chk.sv
module dsat_ssd_chan_chk #(
   parameter int SSD_CYC = 480
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_on,
   input logic force_off,
   input logic src_en,
   input logic snk_en,
   input logic ssd_en,
   input logic boost_en,
   input logic ssd_active,
   input logic ssd_done
);
   localparam int W = dsc_pkg::cnt_bits(SSD_CYC + 1);

   logic [W-1:0] act_run;

   always_ff @(posedge clk) begin
      if (!rst_n || !ssd_active)
         act_run <= '0;
      else
         act_run <= act_run + 1'b1;
   end

   p_stage_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({src_en, snk_en, ssd_en}));

   p_cmd_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_on |=> !src_en);

   p_boost_in_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      boost_en |-> src_en);

   p_ssd_from_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ssd_en) |-> $past(src_en));

   p_ssd_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ssd_active) |-> (act_run == W'(SSD_CYC)));

   p_done_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ssd_active) |-> (ssd_done && snk_en));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ssd_done |=> !ssd_done);

   p_hold_after_ssd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ssd_done |=> !src_en);
endmodule

bind dsat_ssd_chan dsat_ssd_chan_chk #(.SSD_CYC(SSD_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_on    (cmd_on),
   .force_off (force_off),
   .src_en    (src_en),
   .snk_en    (snk_en),
   .ssd_en    (ssd_en),
   .boost_en  (boost_en),
   .ssd_active(ssd_active),
   .ssd_done  (ssd_done)
);

// File: tb/test_dsat_ssd_chan.sv
module test_dsat_ssd_chan;
   localparam int T_BLANK = 6;
   localparam int T_FILT  = 3;
   localparam int T_SSD   = 8;
   localparam int T_BOOST = 2;
   localparam int NVEC    = 14;

   // {cmd_on, desat_in, force_off, src, snk, ssd, boost, active, done}
   localparam logic [8:0] VEC [NVEC] = '{
      9'b000_010000,  // R3 idle off
      9'b100_100100,  // R3 R4 on, boost
      9'b100_100100,  // R4 boost second cycle
      9'b100_100000,  // R4 boost over
      9'b000_010000,  // R3 off
      9'b101_010000,  // R3 force blocks on
      9'b100_100100,  // R3 on again, fresh boost
      9'b101_010000,  // R3 force turns off
      9'b010_010000,  // R7 desat while off
      9'b010_010000,  // R7
      9'b010_010000,  // R7
      9'b110_100100,  // R5 R7 turn on with desat high
      9'b110_100100,  // R5
      9'b000_010000   // R3 off
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_on = 1'b0;
   logic desat_in = 1'b0;
   logic force_off = 1'b0;
   logic src_en, snk_en, ssd_en, boost_en, ssd_active, ssd_done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dsat_ssd_chan #(
      .BLANK_CYC(T_BLANK),
      .FILT_CYC (T_FILT),
      .SSD_CYC  (T_SSD),
      .BOOST_CYC(T_BOOST)
   ) i_dsat_ssd_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_on    (cmd_on),
      .desat_in  (desat_in),
      .force_off (force_off),
      .src_en    (src_en),
      .snk_en    (snk_en),
      .ssd_en    (ssd_en),
      .boost_en  (boost_en),
      .ssd_active(ssd_active),
      .ssd_done  (ssd_done)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_in(input logic c, input logic d, input logic f);
      cmd_on    = c;
      desat_in  = d;
      force_off = f;
   endtask

   // compare {src,snk,ssd,boost,active,done} under a mask
   task automatic chk(input string tag, input logic [5:0] exp, input logic [5:0] mask);
      logic [5:0] act;
      act = {src_en, snk_en, ssd_en, boost_en, ssd_active, ssd_done};
      n_chk++;
      if ((act & mask) !== (exp & mask)) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b (mask %b) at %0t",
                  tag, act, exp, mask, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      step();
      step();
      chk("R1 reset encoding", 6'b010000, 6'b111111);
      rst_n = 1'b1;

      // table walk: each row applied at one negedge, checked at the next
      for (int r = 0; r <= NVEC; r++) begin
         step();
         if (r > 0)
            chk($sformatf("R2/R3 table row %0d", r - 1), VEC[r-1][5:0], 6'b111111);
         if (r < NVEC)
            set_in(VEC[r][8], VEC[r][7], VEC[r][6]);
      end

      // blanking, filtering and confirmed soft shutdown
      step();
      set_in(1, 0, 0);
      for (int k = 1; k <= 6; k++) begin
         step();
         if (k == 1) chk("R4 boost at turn-on", 6'b100100, 6'b111100);
         set_in(1, 1, 0);
      end
      for (int k = 7; k <= 10; k++) begin
         step();
         chk("R5 desat inside blanking ignored", 6'b100000, 6'b111010);
         set_in(1, 0, 0);
      end
      for (int k = 11; k <= 12; k++) begin
         step();
         chk("R6 short pulse", 6'b100000, 6'b111010);
         set_in(1, 1, 0);
      end
      for (int k = 13; k <= 15; k++) begin
         step();
         chk("R6 short pulse filtered", 6'b100000, 6'b111010);
         set_in(1, 0, 0);
      end
      for (int k = 16; k <= 18; k++) begin
         step();
         chk("R6 not yet confirmed", 6'b100000, 6'b111010);
         set_in(1, 1, 0);
      end
      for (int j = 0; j < T_SSD; j++) begin
         step();
         chk($sformatf("R8 soft shutdown cycle %0d", j), 6'b001010, 6'b111011);
         set_in(j[0], j[2], (j == 2) || (j == 3));
      end
      step();
      chk("R9 done pulse at end", 6'b010001, 6'b111011);
      set_in(1, 0, 0);
      for (int k = 28; k <= 32; k++) begin
         step();
         chk("R10 held off after shutdown", 6'b010000, 6'b111111);
         if (k == 30 || k == 31) set_in(1, 0, 1);
         else                    set_in(1, 0, 0);
      end
      step();
      chk("R10 released to off", 6'b010000, 6'b111000);
      set_in(1, 0, 0);
      step();
      chk("R10 turns on after release", 6'b100100, 6'b111100);

      // R1 reset from the on state
      step();
      rst_n = 1'b0;
      step();
      step();
      chk("R1 reset from on", 6'b010000, 6'b111111);
      set_in(0, 0, 0);
      rst_n = 1'b1;

      // R11 confirm and force-off in the same cycle
      step();
      set_in(1, 0, 0);
      for (int m = 1; m <= 6; m++) begin
         step();
         set_in(1, 0, 0);
      end
      for (int m = 7; m <= 8; m++) begin
         step();
         set_in(1, 1, 0);
      end
      step();
      chk("R11 still on before confirm", 6'b100000, 6'b111000);
      set_in(1, 1, 1);
      step();
      chk("R11 soft shutdown beats force-off", 6'b001010, 6'b111010);
      set_in(0, 0, 0);
      repeat (T_SSD + 2) step();
      chk("R10 held after second shutdown", 6'b010000, 6'b111000);

      finish_run();
   end
endmodule